// File: doc/BRIEF.md
# Three-wire serial EEPROM word controller

This block is the master for a small serial EEPROM that uses a three-wire protocol. The three wires are an active-high select, a serial clock and a data line into the memory, plus one data line back from the memory. A client asks for a run of words by giving a start word and a word count. For a read, the block streams each word back with a one-cycle valid pulse. For a write, the block shows the index of the word it needs on `word_idx`, and the client supplies that word combinationally on `wr_data`. When the request is complete, `done` pulses for one cycle and `err` reports the outcome.

Each word is a self-contained command: a start bit and opcode, then the address, then 16 data bits, then a standby sequence. The memory never auto-increments. A write run opens with an erase/write-enable frame and closes with an erase/write-disable frame. After every word it writes, the block polls the returned data line until the memory reports ready, and it gives up after a bounded number of attempts. The opcode width, address width, memory size, serial half-period (counted in system clocks) and poll limit are parameters.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: A request is rejected when its offset is at least the word count of the memory, when its count is zero, or when its count exceeds the words left above the offset. A rejected request pulses `done` with `err` high on the next cycle and leaves select low throughout.
- R2: Select is active high. While the block is idle, select and clock are low. At the start of a request, clock and data-in are low before select rises. An asynchronous reset returns all three lines low.
- R3: Every frame is shifted most significant bit first. Data-in changes only while the serial clock is low, so it is stable over each rising clock edge.
- R4: Each read word is a separate frame: opcode 110 followed by the address offset+i (i counts from 0). The block then clocks in 16 bits, MSB first, sampling the returned line while the clock is high, and presents the word with a one-cycle `rd_valid`.
- R5: A standby sequence follows each command frame. It drops select and clock, raises the clock, raises select, then lowers the clock. A read of N words produces N+1 clock rises with select low (one of them from the stop sequence), and a write of N words produces 2N+2.
- R6: A write run begins with the enable frame, which is 10011 followed by address-width−2 zero bits. It ends with the disable frame, which is 10000 followed by the same zero padding. Between the two are one write frame per word.
- R7: Each write frame is opcode 101, the address offset+i, and 16 data bits. After its standby, the block samples the returned line once per half-period while select is high. A high value moves on to the next word. After POLL_MAX low samples, the block ends the request with `err` high and sends no disable frame.
- R8: Every accepted request finishes with a stop sequence: select and data-in go low, then the clock gives one pulse. `done` rises with all three lines low.
- R9: `busy` is high from acceptance until `done`. `done` pulses exactly when `busy` falls, and `err` is low for a request that completed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write run, 0 = read run |
| req_offset | input | 16 | First word address |
| req_count | input | 16 | Number of words |
| wr_data | input | 16 | Word to write for the current `word_idx` |
| word_idx | output | 16 | Index of the word in progress within the run |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 16 | Word read from the memory |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Failure flag, valid with `done` |
| ee_cs | output | 1 | Memory select, active high |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The bench drives a behavioural memory with single-word, multi-word and whole-array reads, and with two-word writes, including runs that touch the first and last addresses. A mistake in address ordering or in bit order therefore appears as a wrong logged address or a wrong data word. Rejected requests cover an offset just past the end, a run that overflows the end, and a zero count, which separates the three range terms. A memory held busy exercises the poll limit, and the bench confirms that the disable frame is missing in that case. A reset in the middle of a read shows that the lines return low and that the next request runs cleanly.

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl #(
  parameter int OPB      = 3,
  parameter int AW       = 6,
  parameter int WORD_CNT = 64,
  parameter int HALF     = 2,
  parameter int POLL_MAX = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_offset,
  input  logic [15:0] req_count,
  input  logic [15:0] wr_data,
  output logic [15:0] word_idx,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int CMD_W = OPB + AW;
  localparam int SH_W  = (CMD_W > 16) ? CMD_W : 16;
  localparam int TW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW    = $clog2(SH_W + 1);
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam logic [OPB-1:0]   RD_OP     = OPB'(6);
  localparam logic [OPB-1:0]   WR_OP     = OPB'(5);
  localparam logic [CMD_W-1:0] EN_FRAME  = CMD_W'(19) << (AW - 2);
  localparam logic [CMD_W-1:0] DIS_FRAME = CMD_W'(16) << (AW - 2);

  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_EWEN, S_SBEN, S_CMD, S_RDIN, S_WDAT,
    S_SBW1, S_POLL, S_SBW2, S_SBR, S_EWDS, S_STOP
  } st_t;

  st_t             st;
  logic [1:0]      step;
  logic [TW-1:0]   tcnt;
  logic [SH_W-1:0] sh;
  logic [BW-1:0]   nb;
  logic [15:0]     base, cnt, idx, rin;
  logic [PW-1:0]   pcnt;
  logic            wr;

  wire             tick = (tcnt == TW'(HALF - 1));
  wire             last = (idx == cnt);
  wire [16:0]      room = 17'(WORD_CNT) - {1'b0, req_offset};
  wire             bad  = ({1'b0, req_offset} >= 17'(WORD_CNT)) ||
                          ({1'b0, req_count} > room) || (req_count == 16'd0);
  wire [AW-1:0]    waddr = AW'(base + idx);
  wire [CMD_W-1:0] cmd_frame = {wr ? WR_OP : RD_OP, waddr};
  wire [SH_W-1:0]  cmd_al = SH_W'(cmd_frame) << (SH_W - CMD_W);
  wire [SH_W-1:0]  en_al  = SH_W'(EN_FRAME) << (SH_W - CMD_W);
  wire [SH_W-1:0]  dis_al = SH_W'(DIS_FRAME) << (SH_W - CMD_W);
  wire [SH_W-1:0]  dat_al = SH_W'(wr_data) << (SH_W - 16);

  assign busy     = (st != S_IDLE);
  assign word_idx = idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else if (st == S_IDLE || tick) tcnt <= '0;
    else tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; sh <= '0; nb <= '0;
      base <= '0; cnt <= '0; idx <= '0; rin <= '0; pcnt <= '0; wr <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; err <= 1'b0;
      ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (bad) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            st <= S_PREP; step <= '0; err <= 1'b0;
            base <= req_offset; cnt <= req_count; idx <= '0; wr <= req_write;
            ee_sk <= 1'b0; ee_di <= 1'b0;
          end
        end
        S_PREP: if (tick) begin
          if (step == 2'd0) begin
            ee_cs <= 1'b1; step <= 2'd1;
          end else begin
            step <= 2'd0;
            if (wr) begin
              st <= S_EWEN; sh <= en_al; nb <= BW'(CMD_W); ee_di <= en_al[SH_W-1];
            end else begin
              st <= S_CMD; sh <= cmd_al; nb <= BW'(CMD_W); ee_di <= cmd_al[SH_W-1];
            end
          end
        end
        S_EWEN, S_CMD, S_WDAT, S_EWDS: if (tick) begin
          if (step == 2'd0) begin
            ee_sk <= 1'b1; step <= 2'd1;
          end else begin
            ee_sk <= 1'b0; step <= 2'd0; sh <= sh << 1; nb <= nb - 1'b1;
            if (nb == BW'(1)) begin
              ee_di <= 1'b0;
              case (st)
                S_EWEN: st <= S_SBEN;
                S_CMD:
                  if (wr) begin
                    st <= S_WDAT; sh <= dat_al; nb <= BW'(16); ee_di <= dat_al[SH_W-1];
                  end else begin
                    st <= S_RDIN; nb <= BW'(16);
                  end
                S_WDAT:  st <= S_SBW1;
                default: st <= S_STOP;
              endcase
            end else begin
              ee_di <= sh[SH_W-2];
            end
          end
        end
        S_RDIN: if (tick) begin
          if (step == 2'd0) begin
            ee_sk <= 1'b1; step <= 2'd1;
          end else begin
            ee_sk <= 1'b0; step <= 2'd0; nb <= nb - 1'b1;
            rin <= {rin[14:0], ee_do};
            if (nb == BW'(1)) begin
              rd_data <= {rin[14:0], ee_do}; rd_valid <= 1'b1;
              idx <= idx + 16'd1; st <= S_SBR;
            end
          end
        end
        S_SBEN, S_SBW1, S_SBW2, S_SBR: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0: begin ee_cs <= 1'b0; ee_sk <= 1'b0; end
            2'd1: ee_sk <= 1'b1;
            2'd2: ee_cs <= 1'b1;
            default: begin
              ee_sk <= 1'b0; step <= 2'd0;
              if (st == S_SBW1) begin
                st <= S_POLL; pcnt <= '0;
              end else if (st != S_SBEN && last) begin
                if (st == S_SBR) st <= S_STOP;
                else begin
                  st <= S_EWDS; sh <= dis_al; nb <= BW'(CMD_W); ee_di <= dis_al[SH_W-1];
                end
              end else begin
                st <= S_CMD; sh <= cmd_al; nb <= BW'(CMD_W); ee_di <= cmd_al[SH_W-1];
              end
            end
          endcase
        end
        S_POLL: if (tick) begin
          if (ee_do) begin
            idx <= idx + 16'd1; st <= S_SBW2;
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            err <= 1'b1; st <= S_STOP;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          case (step)
            2'd0: begin ee_cs <= 1'b0; ee_di <= 1'b0; step <= 2'd1; end
            2'd1: begin ee_sk <= 1'b1; step <= 2'd2; end
            default: begin ee_sk <= 1'b0; step <= 2'd0; st <= S_IDLE; done <= 1'b1; end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && bad) |=> (done && err && !busy && !ee_cs));

  assert_idle_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  assert_di_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ee_di) |-> !ee_sk);

  assert_rdv_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !wr));

  assert_poll_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (ee_cs && !ee_sk));

  assert_stop_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !ee_sk && !ee_di));

  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/uwire_eeprom_ctrl_tb_top.sv
module uwire_eeprom_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPB = 3, AW = 6, WORD_CNT = 64, HALF = 2, POLL_MAX = 200;
  localparam int CMD_W = OPB + AW;
  localparam int BUSY_CLK = 30;
  localparam logic [CMD_W-1:0] EXP_EN  = CMD_W'(9'h130);
  localparam logic [CMD_W-1:0] EXP_DIS = CMD_W'(9'h100);
  localparam int NV = 12;
  // {write, expect_err, offset, count}
  localparam logic [39:0] VEC [NV] = '{
    {4'h0, 4'h0, 16'd0,  16'd1},
    {4'h0, 4'h0, 16'd5,  16'd3},
    {4'h0, 4'h0, 16'd63, 16'd1},
    {4'h1, 4'h0, 16'd10, 16'd2},
    {4'h1, 4'h0, 16'd62, 16'd2},
    {4'h0, 4'h0, 16'd9,  16'd4},
    {4'h0, 4'h0, 16'd61, 16'd3},
    {4'h0, 4'h1, 16'd64, 16'd1},
    {4'h0, 4'h1, 16'd60, 16'd5},
    {4'h1, 4'h1, 16'd3,  16'd0},
    {4'h0, 4'h0, 16'd0,  16'd64},
    {4'h0, 4'h1, 16'd63, 16'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_offset = '0, req_count = '0, wpat = '0;
  logic [15:0] wr_data, word_idx, rd_data;
  logic rd_valid, busy, done, err, ee_cs, ee_sk, ee_di, ee_do;

  assign wr_data = wpat ^ word_idx;
  always #(CLK_PERIOD / 2) clk = ~clk;

  uwire_eeprom_ctrl #(.OPB(OPB), .AW(AW), .WORD_CNT(WORD_CNT), .HALF(HALF), .POLL_MAX(POLL_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_count(req_count), .wr_data(wr_data),
    .word_idx(word_idx), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .done(done), .err(err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  function automatic logic [15:0] initpat(input int a);
    return 16'h9C31 ^ 16'(a * 291);
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory
  logic [15:0] mem [WORD_CNT];
  bit written [WORD_CNT];
  logic cs_q = 1'b0, wen = 1'b0, do_r = 1'b0, hang = 1'b0;
  logic [CMD_W-1:0] cmdr = '0;
  logic [AW-1:0] maddr = '0;
  logic [15:0] wbuf = '0, tmpw;
  int bitn = 0, mode = 4, k = 0, busy_until = 0;
  int cs_rise = 0, sb_cnt = 0, log_n = 0;
  int log_code [512];
  int log_addr [512];

  function automatic logic [15:0] dev_word(input int a);
    return written[a] ? mem[a] : initpat(a);
  endfunction

  assign ee_do = (mode == 1) ? do_r : !(hang || (cyc < busy_until));

  always @(ee_cs or posedge ee_sk) begin
    if (ee_cs !== cs_q) begin
      if (ee_cs) begin
        cs_rise++; bitn = 0; mode = 0; cmdr = '0;
      end else begin
        if (mode == 3 && wen) begin
          mem[maddr] = wbuf; written[maddr] = 1'b1; busy_until = cyc + BUSY_CLK;
        end
        mode = 4;
      end
      cs_q = ee_cs;
    end else if (ee_sk) begin
      if (!ee_cs) sb_cnt++;
      else case (mode)
        0: begin
          cmdr = {cmdr[CMD_W-2:0], ee_di}; bitn++;
          if (bitn == CMD_W) begin
            maddr = cmdr[AW-1:0]; k = 0; wbuf = '0;
            log_addr[log_n] = int'(cmdr[AW-1:0]);
            if (cmdr == EXP_EN) begin log_code[log_n] = 1; wen = 1'b1; mode = 4; end
            else if (cmdr == EXP_DIS) begin log_code[log_n] = 2; wen = 1'b0; mode = 4; end
            else if (cmdr[CMD_W-1:AW] == 3'b110) begin log_code[log_n] = 3; mode = 1; end
            else if (cmdr[CMD_W-1:AW] == 3'b101) begin log_code[log_n] = 4; mode = 2; end
            else begin log_code[log_n] = 9; mode = 4; end
            log_n++;
          end
        end
        1: begin tmpw = dev_word(int'(maddr)); do_r = tmpw[15 - k]; k++; end
        2: begin wbuf = {wbuf[14:0], ee_di}; k++; if (k == 16) mode = 3; end
        default: ;
      endcase
    end
  end

  logic [15:0] got [256];
  int ng = 0;
  always @(negedge clk) if (rd_valid) begin got[ng] = rd_data; ng++; end

  int total = 0, bad = 0;
  logic [15:0] exp_mem [WORD_CNT];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic w, input logic [15:0] off, input logic [15:0] n,
                         output logic e, output int used);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_offset = off; req_count = n;
    @(negedge clk);
    req_valid = 1'b0;
    used = 1;
    while (!done && used < 30000) begin @(negedge clk); used++; end
    chk(done, "R9", "watchdog: done seen", int'(done), 1);
    e = err;
    chk(!ee_cs && !ee_sk && !ee_di, "R8", "lines low at done", {ee_cs, ee_sk, ee_di}, 0);
  endtask

  initial begin
    logic e;
    int used, l0, s0, c0, g0, off, n;
    for (int a = 0; a < WORD_CNT; a++) exp_mem[a] = initpat(a);
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di && !busy && !done && !rd_valid, "R2", "reset state",
        {ee_cs, ee_sk, ee_di, busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      off = int'(VEC[v][31:16]); n = int'(VEC[v][15:0]);
      wpat = 16'h3C00 + 16'(v << 8);
      l0 = log_n; s0 = sb_cnt; c0 = cs_rise; g0 = ng;
      run_req(VEC[v][36], VEC[v][31:16], VEC[v][15:0], e, used);
      chk(e == VEC[v][32], VEC[v][32] ? "R1" : "R9", "err flag", int'(e), int'(VEC[v][32]));
      if (VEC[v][32]) begin
        chk(cs_rise == c0 && log_n == l0, "R1", "no bus activity", cs_rise - c0, 0);
        chk(used == 1, "R1", "reject latency", used, 1);
      end else if (!VEC[v][36]) begin
        chk(ng - g0 == n, "R4", "words returned", ng - g0, n);
        for (int i = 0; i < n; i++) begin
          chk(got[g0 + i] == exp_mem[off + i], "R4", "read word", int'(got[g0 + i]), int'(exp_mem[off + i]));
          chk(log_code[l0 + i] == 3 && log_addr[l0 + i] == off + i, "R3", "read frame addr",
              log_addr[l0 + i], off + i);
        end
        chk(log_n - l0 == n, "R4", "frame count", log_n - l0, n);
        chk(sb_cnt - s0 == n + 1, "R5", "standby pulses (read)", sb_cnt - s0, n + 1);
        chk(cs_rise - c0 == n + 1, "R2", "select rises (read)", cs_rise - c0, n + 1);
      end else begin
        for (int i = 0; i < n; i++) exp_mem[off + i] = wpat ^ 16'(i);
        chk(log_n - l0 == n + 2, "R6", "frame count", log_n - l0, n + 2);
        chk(log_code[l0] == 1, "R6", "enable frame first", log_code[l0], 1);
        chk(log_code[l0 + n + 1] == 2, "R6", "disable frame last", log_code[l0 + n + 1], 2);
        for (int i = 0; i < n; i++) begin
          chk(log_code[l0 + 1 + i] == 4 && log_addr[l0 + 1 + i] == off + i, "R7", "write frame addr",
              log_addr[l0 + 1 + i], off + i);
          chk(dev_word(off + i) == exp_mem[off + i], "R7", "stored word",
              int'(dev_word(off + i)), int'(exp_mem[off + i]));
        end
        chk(!wen, "R6", "memory left write-protected", int'(wen), 0);
        chk(sb_cnt - s0 == 2 * n + 2, "R5", "standby pulses (write)", sb_cnt - s0, 2 * n + 2);
        chk(ng == g0, "R4", "no read strobes on write", ng - g0, 0);
      end
    end

    // poll limit: memory never reports ready
    hang = 1'b1; wpat = 16'hBEEF; l0 = log_n;
    run_req(1'b1, 16'd20, 16'd2, e, used);
    hang = 1'b0;
    exp_mem[20] = 16'hBEEF;
    chk(e == 1'b1, "R7", "timeout error", int'(e), 1);
    chk(log_n - l0 == 2 && log_code[l0] == 1 && log_code[l0 + 1] == 4, "R7", "frames before timeout",
        log_n - l0, 2);
    chk(used > POLL_MAX * HALF, "R7", "poll duration", used, POLL_MAX * HALF);
    chk(wen, "R7", "no disable frame after timeout", int'(wen), 1);

    // reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = 16'd0; req_count = 16'd4;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di && !busy, "R2", "lines after reset", {ee_cs, ee_sk, ee_di, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    g0 = ng;
    run_req(1'b0, 16'd20, 16'd1, e, used);
    chk(!e && ng - g0 == 1 && got[g0] == exp_mem[20], "R4", "read after reset",
        int'(got[g0]), int'(exp_mem[20]));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule